// File: doc/BRIEF.md
# Five-Cell Loop Port Bypass Ring

This block routes a bit-serial loop through five cells arranged in a closed ring. Each cell holds a 2:1 selector. The selector either inserts the cell's attached node into the loop or skips that node and passes the upstream loop data on unchanged. The value selected in cell x leaves on the node output of cell x+1, and the last cell wraps round to node output 0. Each cell registers its selection on a clock-enabled bit boundary, so the delay around the loop equals the number of cells the data passes through.

Cell 0 has a single-register retiming stage that can be switched in or out of the path. A run-length monitor watches the retimer output and raises a data-valid flag at the end of each fixed-length frame. In auto-bypass mode the retimer takes node input 0, and an invalid flag forces cell 0 into bypass. In forwarding mode the retimer sits after cell 0 and always feeds node output 1, whatever the flag says. Two shared active-low strobes, combined with per-node select lines, turn off individual output drivers and equalizer enables. Every control input passes through a two-flop synchronizer before it takes effect.

Top module: `loop_bypass_ring`

## Requirements
- R1: After reset every node output is 0, every output enable and equalizer enable is 1, and the data-valid flag is 0.
- R2: With its bypass control high, cell x drives node input x onto node output (x+1) mod 5 one enabled bit later.
- R3: With its bypass control low, cell x passes the data it receives on node output x to node output (x+1) mod 5, so node 4's data wraps to node output 0.
- R4: While the bit enable is low, no node output changes, even if the node inputs change.
- R5: With the retime select high, node input 0 reaches node output 1 after two enabled bits. With the retime select low, it arrives after one.
- R6: With the mode select low, the data from cell 0 reaches node output 1 even when the data-valid flag is 0.
- R7: The data-valid flag changes only at the end of a 20-bit frame. It is then 1 when the monitored stream had no run of identical bits longer than 5 during that frame, and 0 otherwise.
- R8: With the mode select high, the flag at 0 and bypass 0 high, cell 0 skips node input 0 and passes the upstream loop data. With the flag at 1, node input 0 is inserted.
- R9: Output enable x is 0 only when the output strobe and node select x are both 0. A disabled port drives a constant 1 on its node output.
- R10: Equalizer enable x is 0 only when the equalizer strobe and node select x are both 0.
- R11: A change on a control input affects the outputs no earlier than the second clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One serial bit per clock when high |
| node_in | input | 5 | Data returning from each node |
| byp_n | input | 5 | Per-cell bypass, low skips the node |
| retime_en | input | 1 | Switches the cell-0 retimer into the path |
| dv_mode | input | 1 | High: auto-bypass on data-valid; low: forwarding |
| oe_strobe_n | input | 1 | Shared output-disable strobe, active low |
| eq_strobe_n | input | 1 | Shared equalizer-disable strobe, active low |
| node_sel | input | 5 | Per-node select used with both strobes |
| node_out | output | 5 | Data sent to each node |
| out_en | output | 5 | Per-port output driver enable |
| eq_en | output | 5 | Per-port equalizer enable |
| dv_flag | output | 1 | Data-valid result of the last frame |

## Verification
The bench uses five and six identical bits as the two sides of the run-length limit. A monitor that is off by one either drops the flag on legal traffic or never bypasses a bad node.

Latency is measured bit by bit with the retimer in and out, so a missing or doubled register stage shows up as a shifted edge on node output 1. Patterns with one or two inserted cells make the data wrap around the ring. These catch a design that routes a cell's selection to its own port instead of the next port.

The bench also checks that each disable needs both lows. A design that used OR instead of AND would turn off ports while the shared strobe is still high. Finally, the bench samples one cycle after each control change to catch a synchronizer that is missing a stage.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  // A port stays on unless the shared strobe and its own select are both low.
  function automatic logic keep_on(input logic strobe_n, input logic sel);
    return strobe_n | sel;
  endfunction

  // Index of the cell feeding port i around a ring of n cells.
  function automatic int unsigned ring_prev(input int unsigned i, input int unsigned n);
    return (i + n - 1) % n;
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/pbc_cell.sv
module pbc_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic insert,
  input  logic node_d,
  input  logic loop_d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else if (bit_en) q <= insert ? node_d : loop_d;
  end

  AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(q)); // R4
  AST_CELL_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && insert) |=> q == $past(node_d)); // R2
  AST_CELL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !insert) |=> q == $past(loop_d)); // R3
endmodule

// File: rtl/dv_monitor.sv
module dv_monitor #(
  parameter int unsigned FRAME_BITS = 20,
  parameter int unsigned RUN_MAX    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic din,
  output logic dv,
  output logic frame_end,
  output logic viol
);
  localparam int unsigned FW = $clog2(FRAME_BITS);
  localparam int unsigned RW = $clog2(RUN_MAX + 2);

  logic [FW-1:0] frame_cnt;
  logic [RW-1:0] run_len, run_nx;
  logic          last_bit, bad_frame;

  always_comb begin
    if (din != last_bit)             run_nx = RW'(1);
    else if (run_len > RW'(RUN_MAX)) run_nx = run_len;
    else                             run_nx = run_len + 1'b1;
  end

  assign viol      = bit_en && (run_nx > RW'(RUN_MAX));
  assign frame_end = bit_en && (frame_cnt == FW'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      run_len   <= '0;
      last_bit  <= 1'b0;
      bad_frame <= 1'b0;
      dv        <= 1'b0;
    end else if (bit_en) begin
      last_bit <= din;
      run_len  <= run_nx;
      if (frame_end) begin
        dv        <= !(bad_frame || viol);
        bad_frame <= 1'b0;
        frame_cnt <= '0;
      end else begin
        bad_frame <= bad_frame || viol;
        frame_cnt <= frame_cnt + 1'b1;
      end
    end
  end

  AST_DV_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(dv)); // R7
  AST_DV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && viol) |=> !dv); // R7
endmodule

// File: rtl/loop_bypass_ring.sv
module loop_bypass_ring #(
  parameter int unsigned N          = 5,
  parameter int unsigned FRAME_BITS = 20,
  parameter int unsigned RUN_MAX    = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic [N-1:0] node_in,
  input  logic [N-1:0] byp_n,
  input  logic         retime_en,
  input  logic         dv_mode,
  input  logic         oe_strobe_n,
  input  logic         eq_strobe_n,
  input  logic [N-1:0] node_sel,
  output logic [N-1:0] node_out,
  output logic [N-1:0] out_en,
  output logic [N-1:0] eq_en,
  output logic         dv_flag
);
  localparam int unsigned CW = 2 * N + 4;
  localparam logic [CW-1:0] CTL_RST = {{N{1'b1}}, {N{1'b1}}, 4'b0011};

  logic [CW-1:0] ctl_s;
  logic [N-1:0]  byp_s, sel_s;
  logic          retime_s, dvmode_s, oe_s, eq_s;

  ctl_sync #(.W(CW), .RST_VAL(CTL_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({byp_n, node_sel, retime_en, dv_mode, oe_strobe_n, eq_strobe_n}),
    .q(ctl_s)
  );
  assign {byp_s, sel_s, retime_s, dvmode_s, oe_s, eq_s} = ctl_s;

  // Loop fabric: cell_q[x] is what cell x selected, ring[x] is what port x carries.
  logic [N-1:0] cell_q, ring;
  logic         rt_q, rt_d, head_d, ins0, ring1, dv_frame_end, dv_viol;

  assign ins0   = byp_s[0] & (dv_flag | !dvmode_s);
  assign head_d = (dvmode_s && retime_s) ? rt_q : node_in[0];
  assign rt_d   = dvmode_s ? node_in[0] : cell_q[0];
  assign ring1  = (!dvmode_s && retime_s) ? rt_q : cell_q[0];

  always_comb begin
    for (int unsigned x = 0; x < N; x++)
      ring[x] = cell_q[lbr_pkg::ring_prev(x, N)];
    ring[1] = ring1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rt_q <= 1'b0;
    else if (bit_en) rt_q <= rt_d;
  end

  dv_monitor #(.FRAME_BITS(FRAME_BITS), .RUN_MAX(RUN_MAX)) u_dv (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(rt_q),
    .dv(dv_flag), .frame_end(dv_frame_end), .viol(dv_viol)
  );

  for (genvar x = 0; x < N; x++) begin : g_cell
    if (x == 0) begin : g_head
      pbc_cell u_cell (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .insert(ins0),
        .node_d(head_d), .loop_d(ring[0]), .q(cell_q[0])
      );
    end else begin : g_body
      pbc_cell u_cell (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .insert(byp_s[x]),
        .node_d(node_in[x]), .loop_d(ring[x]), .q(cell_q[x])
      );
    end
    assign out_en[x]   = lbr_pkg::keep_on(oe_s, sel_s[x]);
    assign eq_en[x]    = lbr_pkg::keep_on(eq_s, sel_s[x]);
    assign node_out[x] = out_en[x] ? ring[x] : 1'b1;
  end

  AST_AUTO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && dvmode_s && !dv_flag) |=> cell_q[0] == $past(ring[0])); // R8
  AST_FWD_RETIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !dvmode_s) |=> rt_q == $past(cell_q[0])); // R6
endmodule

// File: tb/loop_bypass_ring_tb.sv
module loop_bypass_ring_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int FRAME = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b1;
  logic [N-1:0] node_in = '0, byp_n = '1, node_sel = '1;
  logic retime_en = 1'b0, dv_mode = 1'b0, oe_strobe_n = 1'b1, eq_strobe_n = 1'b1;
  logic [N-1:0] node_out, out_en, eq_en;
  logic dv_flag;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_bypass_ring u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .node_in(node_in), .byp_n(byp_n),
    .retime_en(retime_en), .dv_mode(dv_mode), .oe_strobe_n(oe_strobe_n),
    .eq_strobe_n(eq_strobe_n), .node_sel(node_sel), .node_out(node_out),
    .out_en(out_en), .eq_en(eq_en), .dv_flag(dv_flag)
  );

  // {byp_n, node_in}, bit x of each field belongs to cell x
  localparam logic [9:0] VEC [6] = '{
    {5'b11111, 5'b10110}, {5'b11110, 5'b01011}, {5'b00001, 5'b00001},
    {5'b10000, 5'b01111}, {5'b01010, 5'b10101}, {5'b11011, 5'b00100}
  };

  // Steady state: port x+1 shows the nearest inserted cell at or upstream of x.
  function automatic logic [N-1:0] ring_expect(input logic [N-1:0] byp, input logic [N-1:0] din);
    logic [N-1:0] r;
    for (int x = 0; x < N; x++) begin
      int j = x;
      for (int k = 0; k < N && !byp[j]; k++) j = (j + N - 1) % N;
      r[(x + 1) % N] = din[j];
    end
    return r;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic d, h1, h2;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    check("R1 node_out", node_out, 0);
    check("R1 out_en", out_en, 5'h1f);
    check("R1 eq_en", eq_en, 5'h1f);
    check("R1 dv_flag", dv_flag, 0);

    // R2/R3 vector walk, forwarding mode, retimer out
    foreach (VEC[i]) begin
      byp_n = VEC[i][9:5];
      node_in = VEC[i][4:0];
      step(12);
      check("R2 R3 ring", node_out, ring_expect(VEC[i][9:5], VEC[i][4:0]));
    end

    // R4 hold while bit_en low
    byp_n = '1; node_in = 5'b00000; step(8);
    bit_en = 1'b0; node_in = 5'b11111; step(4);
    check("R4 hold", node_out, 0);
    bit_en = 1'b1; step(2);
    check("R4 resume", node_out, 5'h1f);

    // R5 latency: retimer out then in
    node_in = 5'b00000; step(8);
    node_in[0] = 1'b1; step(1);
    check("R5 direct 1 bit", node_out[1], 1);
    node_in[0] = 1'b0; retime_en = 1'b1; step(8);
    node_in[0] = 1'b1; step(1);
    check("R5 retimed not yet", node_out[1], 0);
    step(1);
    check("R5 retimed 2 bits", node_out[1], 1);

    // R6/R7 forwarding mode with a constant (invalid) stream
    step(3 * FRAME);
    check("R7 constant invalid", dv_flag, 0);
    check("R6 forwarded despite flag", node_out[1], 1);

    // R8 auto-bypass with invalid data: node 4 sends 0
    dv_mode = 1'b1; step(3 * FRAME);
    check("R8 bypass on invalid", node_out[1], 0);
    // runs of exactly 5 are legal
    h1 = 1'b0; h2 = 1'b0;
    for (int k = 0; k < 5 * FRAME; k++) begin
      if (k == 5 * FRAME - 1) check("R8 insert when valid", node_out[1], h2);
      d = ((k / 5) % 2) == 1;
      h2 = h1; h1 = d;
      node_in[0] = d;
      step(1);
    end
    check("R7 run of 5 valid", dv_flag, 1);
    // runs of 6 violate
    for (int k = 0; k < 4 * FRAME; k++) begin
      node_in[0] = ((k / 6) % 2) == 1;
      step(1);
    end
    check("R7 run of 6 invalid", dv_flag, 0);
    check("R8 bypass after drop", node_out[1], 0);
    dv_mode = 1'b0; retime_en = 1'b0; node_in = '0; step(8);

    // R9/R11 output disable needs both lows; sync delay
    oe_strobe_n = 1'b0; node_sel = 5'b10111; step(1);
    check("R11 not before 2 edges", out_en, 5'h1f);
    step(1);
    check("R9 port 3 off", out_en, 5'b10111);
    check("R9 off drives high", node_out, 5'b01000);
    oe_strobe_n = 1'b1; step(4);
    check("R9 strobe high keeps on", out_en, 5'h1f);
    check("R10 eq untouched", eq_en, 5'h1f);

    // R10 equalizer disable
    eq_strobe_n = 1'b0; node_sel = 5'b01101; step(4);
    check("R10 eq pattern", eq_en, 5'b01101);
    check("R9 out untouched", out_en, 5'h1f);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule